// File: doc/BRIEF.md
# Outer-Banked PRG/CHR Bank Mapper

This block sits between a console's CPU and picture-processor buses and the cartridge ROMs. It turns each CPU address in the program window (0x8000–0xFFFF) into an 8 KB program bank number. It turns each pattern-table address (0x0000–0x1FFF) into a 1 KB character bank number. It also reports the nametable mirroring mode.

The CPU programs the block with byte writes to three registers:
- a select register, which picks the bank-data register to load and the slot arrangement;
- eight bank-data registers;
- a mirroring bit.

Two more sources feed the mapping. An outer-bank input adds a high bank bit. A neighbouring protection unit can supply replacement banks for three of the program slots. The mapping outputs are combinational from the registers and inputs. A change to the outer-bank input or to the overrides therefore shows in the same cycle. A register write shows right after the clock edge that takes it. CPU addresses 0x6000–0x7FFF are flagged for work RAM and are not otherwise translated.

Top module: `banked_rom_mapper`

## Requirements
- R1: After reset the select register is 0, the mirroring bit is 0 (vertical), and bank-data registers 0..7 hold 0, 2, 4, 5, 6, 7, 0, 1.
- R2: A write is decoded on `cpu_addr & 0xE001`. 0x8000 loads the select register. 0x8001 loads the bank-data register indexed by select bits [2:0]. 0xA000 loads the mirroring bit. Every other address, including 0xA001, 0xC000 and anything below 0x8000, changes no register.
- R3: With select bit 6 clear, slot 0x8000 uses register 6 and slot 0xC000 uses `prg_bank_count-2`. With bit 6 set, these two swap. Slot 0xA000 always uses register 7, and slot 0xE000 always uses `prg_bank_count-1`.
- R4: The character slot index is `ppu_addr[12:10]` XOR (select bit 7 shifted to index bit 2). Index 0/1 is register 0 with bit 0 forced to 0/1. Index 2/3 is register 1 with bit 0 forced to 0/1. Index 4..7 uses registers 2..5 unchanged. These form `chr_bank[7:0]`.
- R5: A normally mapped program bank is its source value masked to bits [4:0], with `outer_sel` placed at bit 5.
- R6: When `chr_double` is 1, `chr_bank[8]` equals `outer_sel`. Otherwise `chr_bank[8]` is 1 exactly when `ppu_addr[12]` equals select bit 7, which is the half served by registers 0 and 1.
- R7: `mirror_h` is 1 (horizontal) when the last 0xA000 write had data bit 0 set, and 0 (vertical) otherwise.
- R8: While `ovr_active` is 1, slots 0xA000, 0xC000 and 0xE000 output `ovr_a000`, `ovr_c000` and `ovr_e000`. Each is ORed with `outer_sel` at bit 5 and not masked. Slot 0x8000 is unaffected.
- R9: `wram_sel` is 1 exactly for CPU addresses 0x6000–0x7FFF. `prg_bank` is 0 whenever `cpu_addr[15]` is 0.
- R10: Changes to `outer_sel`, `chr_double`, `prg_bank_count` and the override inputs reach the outputs in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | Pattern-table address |
| outer_sel | input | 1 | Outer-bank bit from external register |
| chr_double | input | 1 | Static: character ROM is twice the program ROM size |
| prg_bank_count | input | 8 | Static: number of 8 KB program banks |
| ovr_active | input | 1 | Protection override enable |
| ovr_a000 | input | 6 | Override bank for slot 0xA000 |
| ovr_c000 | input | 6 | Override bank for slot 0xC000 |
| ovr_e000 | input | 6 | Override bank for slot 0xE000 |
| prg_bank | output | 6 | Physical 8 KB program bank for `cpu_addr` |
| wram_sel | output | 1 | CPU address is in the work-RAM window |
| chr_bank | output | 9 | Physical 1 KB character bank for `ppu_addr` |
| mirror_h | output | 1 | 1 = horizontal, 0 = vertical mirroring |

## Verification
The properties assume that addresses, data and the static configuration change only between clock edges. They also assume that `prg_bank_count` is at least 2, so the last and second-to-last banks exist. The directed stimulus drives every input on the falling edge and uses bank counts of 16 and 40. Each output is sampled one nanosecond after its inputs settle. The override properties apply only while `ovr_active` is low, so the bench can raise it freely in its own scenario.

// File: rtl/banked_rom_mapper.sv
module banked_rom_mapper (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic [12:0] ppu_addr,
  input  logic        outer_sel,
  input  logic        chr_double,
  input  logic [7:0]  prg_bank_count,
  input  logic        ovr_active,
  input  logic [5:0]  ovr_a000,
  input  logic [5:0]  ovr_c000,
  input  logic [5:0]  ovr_e000,
  output logic [5:0]  prg_bank,
  output logic        wram_sel,
  output logic [8:0]  chr_bank,
  output logic        mirror_h
);
  localparam logic [15:0] DEC_MASK = 16'hE001;

  logic [7:0] sel_q;
  logic [7:0] bank_q [8];
  logic       mir_q;

  logic wr_sel, wr_data, wr_mir;
  assign wr_sel  = cpu_wr && ((cpu_addr & DEC_MASK) == 16'h8000);
  assign wr_data = cpu_wr && ((cpu_addr & DEC_MASK) == 16'h8001);
  assign wr_mir  = cpu_wr && ((cpu_addr & DEC_MASK) == 16'hA000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= 8'd0;
      mir_q     <= 1'b0;
      bank_q[0] <= 8'd0;
      bank_q[1] <= 8'd2;
      bank_q[2] <= 8'd4;
      bank_q[3] <= 8'd5;
      bank_q[4] <= 8'd6;
      bank_q[5] <= 8'd7;
      bank_q[6] <= 8'd0;
      bank_q[7] <= 8'd1;
    end else begin
      if (wr_sel)  sel_q <= cpu_wdata;
      if (wr_data) bank_q[sel_q[2:0]] <= cpu_wdata;
      if (wr_mir)  mir_q <= cpu_wdata[0];
    end
  end

  assign mirror_h = mir_q;
  assign wram_sel = (cpu_addr[15:13] == 3'b011);

  logic [7:0] last_bank, prev_bank, prg_raw;
  logic [5:0] prg_val, outer_hi;
  assign last_bank = prg_bank_count - 8'd1;
  assign prev_bank = prg_bank_count - 8'd2;
  assign outer_hi  = {outer_sel, 5'd0};

  always_comb begin
    case (cpu_addr[14:13])
      2'd0:    prg_raw = sel_q[6] ? prev_bank : bank_q[6];
      2'd1:    prg_raw = bank_q[7];
      2'd2:    prg_raw = sel_q[6] ? bank_q[6] : prev_bank;
      default: prg_raw = last_bank;
    endcase
    prg_val = {outer_sel, prg_raw[4:0]};
    if (ovr_active) begin
      case (cpu_addr[14:13])
        2'd1:    prg_val = ovr_a000 | outer_hi;
        2'd2:    prg_val = ovr_c000 | outer_hi;
        2'd3:    prg_val = ovr_e000 | outer_hi;
        default: prg_val = {outer_sel, prg_raw[4:0]};
      endcase
    end
  end

  assign prg_bank = cpu_addr[15] ? prg_val : 6'd0;

  logic [2:0] chr_slot;
  logic [7:0] chr_low;
  assign chr_slot = ppu_addr[12:10] ^ {sel_q[7], 2'b00};

  always_comb begin
    case (chr_slot)
      3'd0:    chr_low = {bank_q[0][7:1], 1'b0};
      3'd1:    chr_low = {bank_q[0][7:1], 1'b1};
      3'd2:    chr_low = {bank_q[1][7:1], 1'b0};
      3'd3:    chr_low = {bank_q[1][7:1], 1'b1};
      default: chr_low = bank_q[chr_slot - 3'd2];
    endcase
  end

  assign chr_bank = {chr_double ? outer_sel : (ppu_addr[12] == sel_q[7]), chr_low};
endmodule

// File: rtl/banked_rom_mapper_checker.sv
module banked_rom_mapper_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_wr,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic [12:0] ppu_addr,
  input logic        outer_sel,
  input logic        chr_double,
  input logic [7:0]  prg_bank_count,
  input logic        ovr_active,
  input logic [5:0]  prg_bank,
  input logic [8:0]  chr_bank,
  input logic        mirror_h,
  input logic [7:0]  sel_q
);
  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && ((cpu_addr & 16'hE001) == 16'h8000)) |=> (sel_q == $past(cpu_wdata))); // R2

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && ((cpu_addr & 16'hE001) == 16'h8000)) |=> $stable(sel_q)); // R2

  AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && ((cpu_addr & 16'hE001) == 16'hA000)) |=> $stable(mirror_h)); // R7

  AST_LAST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111 && !ovr_active) |-> (prg_bank[4:0] == 5'(prg_bank_count - 8'd1))); // R3

  AST_PAIR_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_addr[12] == sel_q[7]) |-> (chr_bank[0] == ppu_addr[10])); // R4

  AST_OUTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15] && !ovr_active) |-> (prg_bank[5] == outer_sel)); // R5

  AST_CHR_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    !chr_double |-> (chr_bank[8] == (ppu_addr[12] == sel_q[7]))); // R6

  AST_CHR_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
    chr_double |-> (chr_bank[8] == outer_sel)); // R6

  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[15] |-> (prg_bank == 6'd0)); // R9
endmodule

bind banked_rom_mapper banked_rom_mapper_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .outer_sel(outer_sel),
  .chr_double(chr_double), .prg_bank_count(prg_bank_count),
  .ovr_active(ovr_active), .prg_bank(prg_bank), .chr_bank(chr_bank),
  .mirror_h(mirror_h), .sel_q(sel_q)
);

// File: tb/tb_banked_rom_mapper.sv
module tb_banked_rom_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [12:0] ppu_addr = 13'h0000;
  logic        outer_sel = 1'b0;
  logic        chr_double = 1'b0;
  logic [7:0]  prg_bank_count = 8'd16;
  logic        ovr_active = 1'b0;
  logic [5:0]  ovr_a000 = 6'h00, ovr_c000 = 6'h00, ovr_e000 = 6'h00;
  logic [5:0]  prg_bank;
  logic        wram_sel;
  logic [8:0]  chr_bank;
  logic        mirror_h;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  banked_rom_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .outer_sel(outer_sel),
    .chr_double(chr_double), .prg_bank_count(prg_bank_count),
    .ovr_active(ovr_active), .ovr_a000(ovr_a000), .ovr_c000(ovr_c000),
    .ovr_e000(ovr_e000), .prg_bank(prg_bank), .wram_sel(wram_sel),
    .chr_bank(chr_bank), .mirror_h(mirror_h)
  );

  task automatic cmp(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic chk_prg(string req, logic [15:0] a, int exp);
    cpu_addr = a; #1;
    cmp(req, prg_bank, exp);
  endtask

  task automatic chk_chr(string req, logic [12:0] a, int exp);
    ppu_addr = a; #1;
    cmp(req, chr_bank, exp);
  endtask

  task automatic t_reset;
    chk_prg("R1", 16'h8000, 0);
    chk_prg("R1", 16'hA000, 1);
    chk_prg("R3", 16'hC000, 14);
    chk_prg("R3", 16'hE000, 15);
    chk_chr("R1", 13'h0000, 9'h100);
    chk_chr("R4", 13'h0400, 9'h101);
    chk_chr("R1", 13'h0800, 9'h102);
    chk_chr("R1", 13'h1000, 4);
    chk_chr("R1", 13'h1400, 5);
    chk_chr("R1", 13'h1800, 6);
    chk_chr("R1", 13'h1C00, 7);
    cmp("R1", mirror_h, 0);
  endtask

  task automatic t_prg_swap;
    wr(16'h8000, 8'h06); wr(16'h8001, 8'h3F);
    chk_prg("R5", 16'h8000, 6'h1F);
    outer_sel = 1'b1;
    chk_prg("R10", 16'h8000, 6'h3F);
    outer_sel = 1'b0;
    wr(16'h8000, 8'h46);
    chk_prg("R3", 16'h8000, 14);
    chk_prg("R3", 16'hC000, 6'h1F);
    wr(16'h8000, 8'h07); wr(16'h8001, 8'h25);
    chk_prg("R5", 16'hA000, 5);
    prg_bank_count = 8'd40;
    chk_prg("R5", 16'hE000, 7);
    chk_prg("R5", 16'hC000, 6);
    prg_bank_count = 8'd16;
  endtask

  task automatic t_chr;
    wr(16'h8000, 8'h82); wr(16'h8001, 8'h33);
    chk_chr("R4", 13'h0000, 9'h033);
    chk_chr("R6", 13'h1000, 9'h100);
    chk_chr("R6", 13'h1400, 9'h101);
    wr(16'h8000, 8'h80); wr(16'h8001, 8'h57);
    chk_chr("R4", 13'h1000, 9'h156);
    chk_chr("R4", 13'h1400, 9'h157);
    chr_double = 1'b1; outer_sel = 1'b1;
    chk_chr("R6", 13'h0000, 9'h133);
    outer_sel = 1'b0;
    chk_chr("R6", 13'h1000, 9'h056);
    chr_double = 1'b0;
  endtask

  task automatic t_override;
    wr(16'h8000, 8'h00);
    ovr_active = 1'b1; ovr_a000 = 6'h13; ovr_c000 = 6'h0A; ovr_e000 = 6'h21;
    chk_prg("R8", 16'hE000, 6'h21);
    chk_prg("R8", 16'hC000, 6'h0A);
    chk_prg("R8", 16'hA000, 6'h13);
    chk_prg("R8", 16'h8000, 6'h1F);
    outer_sel = 1'b1;
    chk_prg("R8", 16'hC000, 6'h2A);
    chk_prg("R8", 16'hE000, 6'h21);
    ovr_active = 1'b0; outer_sel = 1'b0;
    chk_prg("R10", 16'hE000, 15);
  endtask

  task automatic t_mirror;
    wr(16'hA000, 8'h01);
    #1 cmp("R7", mirror_h, 1);
    wr(16'hA001, 8'h00);
    #1 cmp("R2", mirror_h, 1);
    wr(16'hA000, 8'h02);
    #1 cmp("R7", mirror_h, 0);
  endtask

  task automatic t_ignored;
    wr(16'hC000, 8'h40);
    chk_prg("R2", 16'h8000, 6'h1F);
    wr(16'h7000, 8'h40);
    chk_prg("R2", 16'h8000, 6'h1F);
    wr(16'h8002, 8'h40);
    chk_prg("R2", 16'h8000, 14);
    wr(16'hE001, 8'hFF);
    chk_prg("R2", 16'hA000, 5);
  endtask

  task automatic t_wram;
    cpu_addr = 16'h6123; #1;
    cmp("R9", wram_sel, 1);
    cmp("R9", prg_bank, 0);
    cpu_addr = 16'h8000; #1;
    cmp("R9", wram_sel, 0);
    cpu_addr = 16'h5FFF; #1;
    cmp("R9", wram_sel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_prg_swap;
    t_chr;
    t_override;
    t_mirror;
    t_ignored;
    t_wram;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule